// File: doc/BRIEF.md
# NRZI Transmit Bit Serializer

This block turns a stream of 16-bit words from an upstream HDLC framer into a single-bit NRZI line. On each bit-clock tick, while transmit is enabled, it sends one channel bit. Data bits leave least significant bit first. A data 0 flips the line level and a data 1 keeps it.

The block has no bit counter. When a word is loaded, a marker bit is placed just above the top data bit of a 17-bit shift register. When only that marker is left, or the register is empty, the block raises `word_req` for one cycle. It takes `word_data` in that same cycle.

The line output lags the encoder by one tick. On a tick, the line first takes the bit encoded on the previous tick, and only then is the next bit encoded. This keeps the line level steady while a new word is being fetched. When the transmit enable is low, the block holds all of its state and requests no words.

Top module: `nrzi_tx_serializer`

## Requirements
- R1: After a synchronous active-low reset, `line_out` is 0, the internal encoded bit is 0, and the shift register is empty. The first enabled tick therefore requests a word.
- R2: On an enabled tick (`bit_tick` and `tx_en` both 1), `line_out` takes the encoded bit computed on the previous enabled tick. It shows this value from the clock edge that ends the tick onward.
- R3: Each enabled tick computes a new encoded bit, which is the inverse of (previous encoded bit XOR the current data bit). So a data 0 toggles the line and a data 1 holds it.
- R4: Within a word, bit 0 is sent first and bit 15 is sent last.
- R5: `word_req` is high only during an enabled tick. It is high on the first enabled tick after reset and then on exactly every 16th enabled tick. `word_data` is taken in the cycle in which `word_req` is high.
- R6: While `tx_en` is 0, the block holds `line_out` and its internal state, and `word_req` stays 0, even if `bit_tick` pulses.
- R7: In cycles without `bit_tick`, `line_out` and the internal state do not change and `word_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per channel bit period |
| tx_en | input | 1 | Transmit enable; when low, the block freezes |
| word_data | input | WORD_W | Next data word, read when `word_req` is high |
| word_req | output | 1 | Asks for a new word and takes `word_data` in the same cycle |
| line_out | output | 1 | NRZI-encoded line bit |

## Verification
The bench builds the block with its default word width of 16. At this width a full refill period of 16 enabled ticks takes only a few dozen cycles, so the bench can run many word boundaries, and several of them meet `tx_en` gaps and missing ticks. The test words are all zeros, all ones, single set bits and mixed patterns. These exercise the toggle and hold cases, the bit order, and the one-tick output lag, including across the hand-off from one word to the next.

// File: rtl/nrzi_tx_pkg.sv
// Shared constants and helpers for the NRZI transmit serializer.
// Assumes nothing beyond a single clock domain.
package nrzi_tx_pkg;
    localparam int unsigned DEF_WORD_W = 16;

    // One NRZI step: a data 1 keeps the level, a data 0 flips it
    function automatic logic nrzi_next(input logic prev_level, input logic data_bit);
        return ~(prev_level ^ data_bit);
    endfunction
endpackage

// File: rtl/nrzi_sentinel_shifter.sv
// Holds the data word plus a marker bit above it, and shifts out one data bit
// per advance. It signals that it needs a word when only the marker, or
// nothing, is left. Assumes word_data is valid whenever a refill happens.
module nrzi_sentinel_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [WORD_W-1:0] word_data,
    output logic              need_word,
    output logic              data_bit
);
    localparam int unsigned SR_W = WORD_W + 1;

    logic [SR_W-1:0] shreg_q;
    logic [SR_W-1:0] cur_v;

    // Empty when every bit above bit 0 is clear (value 0 or 1)
    assign need_word = (shreg_q[SR_W-1:1] == '0);

    // Use a freshly loaded word (with its marker) or the current contents
    always_comb begin
        cur_v = need_word ? {1'b1, word_data} : shreg_q;
    end

    assign data_bit = cur_v[0];

    // Shift one bit out on each advance; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg_q <= '0;
        else if (advance) shreg_q <= cur_v >> 1;
    end
endmodule

// File: rtl/nrzi_encoder.sv
// Holds the running NRZI level and updates it once per advance.
// Assumes data_bit is valid in advance cycles.
module nrzi_encoder
    import nrzi_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic data_bit,
    output logic enc_q
);
    // Step the encoded level on each advance
    always_ff @(posedge clk) begin
        if (!rst_n)       enc_q <= 1'b0;
        else if (advance) enc_q <= nrzi_next(enc_q, data_bit);
    end
endmodule

// File: rtl/nrzi_line_reg.sv
// Output register: on each advance it takes the level encoded on the previous
// advance, so the line is one tick behind the encoder.
module nrzi_line_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic enc_in,
    output logic line_q
);
    // Present the previously encoded bit
    always_ff @(posedge clk) begin
        if (!rst_n)       line_q <= 1'b0;
        else if (advance) line_q <= enc_in;
    end
endmodule

// File: rtl/nrzi_tx_serializer.sv
// Top of the NRZI transmit serializer. It fetches WORD_W-bit words through a
// one-cycle request (data valid in the same cycle), sends them LSB first, and
// drives the line one tick after encoding. Assumes bit_tick is one cycle wide.
module nrzi_tx_serializer
    import nrzi_tx_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_req,
    output logic              line_out
);
    logic advance;
    logic need_word;
    logic data_bit;
    logic enc_q;

    // A bit is sent only on an enabled tick
    assign advance  = bit_tick & tx_en;
    assign word_req = advance & need_word;

    nrzi_sentinel_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .word_data (word_data),
        .need_word (need_word),
        .data_bit  (data_bit)
    );

    nrzi_encoder encoder_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .data_bit (data_bit),
        .enc_q    (enc_q)
    );

    nrzi_line_reg line_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .enc_in  (enc_q),
        .line_q  (line_out)
    );
endmodule

// File: rtl/nrzi_tx_serializer_chk.sv
// Checker for the NRZI transmit serializer, attached to the top through bind.
// It counts enabled ticks between requests so that it can check the refill
// period without a long $past.
module nrzi_tx_serializer_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_en,
    input logic word_req,
    input logic line_out,
    input logic enc_q
);
    localparam int unsigned CW = $clog2(WORD_W + 1) + 1;

    logic [CW-1:0] since_req;
    logic          seen_req;

    // Count enabled ticks since the last request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_req <= '0;
            seen_req  <= 1'b0;
        end else if (bit_tick && tx_en) begin
            since_req <= word_req ? CW'(1) : since_req + CW'(1);
            if (word_req) seen_req <= 1'b1;
        end
    end

    // R5: a request only appears on an enabled tick
    a_r5_req_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        word_req |-> (bit_tick && tx_en));

    // R5: after the first request, requests come exactly every WORD_W enabled ticks
    a_r5_refill_period: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && tx_en && seen_req) |-> (word_req == (since_req == CW'(WORD_W))));

    // R1: the first enabled tick after reset requests a word
    a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && tx_en && !seen_req) |-> word_req);

    // R2: the line takes the previously encoded level on an enabled tick
    a_r2_line_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && tx_en) |=> (line_out == $past(enc_q)));

    // R6 and R7: with no enabled tick, the line and the encoder hold
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && tx_en) |=> ($stable(line_out) && $stable(enc_q)));

    // R6: with transmit disabled, no word is requested
    a_r6_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !word_req);
endmodule

bind nrzi_tx_serializer nrzi_tx_serializer_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_en    (tx_en),
    .word_req (word_req),
    .line_out (line_out),
    .enc_q    (enc_q)
);

// File: tb/nrzi_tx_serializer_tb_top.sv
// Bench: a behavioural reference model (a word queue and a bit countdown)
// compared with the design on every clock.
module nrzi_tx_serializer_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_tick = 1'b0;
    logic         tx_en = 1'b0;
    logic [W-1:0] word_data = '0;
    logic         word_req;
    logic         line_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [W-1:0] words_q[$];
    logic [W-1:0] cur_word;
    int           bits_left = 0;
    logic         m_enc = 1'b0;
    logic         m_line = 1'b0;

    always #5 clk = ~clk;

    nrzi_tx_serializer #(.WORD_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .word_data (word_data),
        .word_req  (word_req),
        .line_out  (line_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check the request, then check the line
    task automatic step(input logic tick, input logic en, input string tag);
        logic exp_req;
        @(negedge clk);
        bit_tick  = tick;
        tx_en     = en;
        word_data = (words_q.size() > 0) ? words_q[0] : '0;
        exp_req   = tick && en && (bits_left == 0);
        #1;
        check({tag, " word_req (R5)"}, word_req, exp_req);
        if (tick && en) begin
            m_line = m_enc;
            if (bits_left == 0) begin
                cur_word  = words_q.pop_front();
                bits_left = W;
            end
            m_enc     = ~(m_enc ^ cur_word[0]);
            cur_word  = cur_word >> 1;
            bits_left = bits_left - 1;
        end
        @(posedge clk);
        #1;
        check({tag, " line_out"}, line_out, m_line);
    endtask

    task automatic send_ticks(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1, tag);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b1, "R7 no tick");
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset line_out", line_out, 1'b0);
        check("R1 reset word_req", word_req, 1'b0);

        words_q.push_back(16'h0000); // R3: every bit toggles
        words_q.push_back(16'hFFFF); // R3: the level holds
        words_q.push_back(16'h0001); // R4: bit 0 goes out first
        words_q.push_back(16'h8000); // R4: bit 15 goes out last
        words_q.push_back(16'hA5C3);
        words_q.push_back(16'h3C96);
        words_q.push_back(16'h1234);
        words_q.push_back(16'hFEDC);
        words_q.push_back(16'h0F0F);

        send_ticks(2 * W, 0, "R3 back-to-back");
        send_ticks(W, 0, "R4 lsb-first 0001");
        send_ticks(W, 2, "R4 lsb-first 8000 R2");
        send_ticks(5, 0, "R2 lag");
        // R6: disabled with ticks present
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R6 disabled");
        send_ticks(W - 5, 1, "R2 after disable");
        // R6 right at a word boundary
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R6 at boundary");
        send_ticks(W, 0, "R5 refill");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7 idle");
        send_ticks(2 * W, 3, "R3 mixed spaced");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R7 final idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule